// File: doc/BRIEF.md
# PWM Emergency Break Controller

This block sits between a four-channel PWM generator and the output pins and provides an emergency shutdown path. An active-low break pin is brought into the clock domain through a synchronizer. When the break path is armed and the synchronized pin is low, a break-active flag is latched. While the flag is set, each PWM output is replaced by a software-chosen safe level. Four synchronous reset strobes are also driven to the timer, covering its counter, its auto-reload register, its duty-cycle registers and its mode bits.

The flag is a latch and not a copy of the pin. It stays set after the pin returns high, and it stays set after the break path is disarmed. Only a software write clears it. A one-cycle interrupt request marks every rising edge of the flag. A single register on a simple write-strobe bus holds the arm bit, the flag and the four safe levels.

Top module: `pwm_brk_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `irq` is low, all four timer reset strobes are low, and `pwm_out` equals `pwm_in`.
- R2: With the arm bit (register bit 0) set, a low level on `brk_pin_n` sets the flag (register bit 1) at the third rising clock edge after the pin falls: two edges for synchronization and one for the latch. With the arm bit clear, a low pin never sets the flag.
- R3: Once set, the flag stays set after the pin returns high, after the arm bit is cleared, and after a write that has a 1 in bit 1. It clears only on a write that has a 0 in bit 1.
- R4: While the flag is set, `pwm_out[i]` equals the safe level in register bit 2+i, for channels 0 to 3. The safe levels take effect in the same cycle in which the flag reads 1.
- R5: While the flag is clear, `pwm_out` follows `pwm_in` combinationally.
- R6: `rst_counter`, `rst_reload`, `rst_duty` and `rst_mode` are high in exactly those cycles in which the flag is set.
- R7: `irq` is high for exactly one cycle on each 0-to-1 transition of the flag, and that cycle is the first cycle in which the flag reads 1.
- R8: A clearing write while the path is armed and the synchronized pin is still low leaves the flag clear for one cycle. The flag then sets again at the next edge and raises `irq` again.
- R9: A write stores bit 0 as the arm bit and bits 5:2 as the safe levels. Software cannot set the flag. Bits 7:6 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| brk_pin_n | input | 1 | Asynchronous break pin, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data: bit0 arm, bit1 flag, bits5:2 safe levels |
| pwm_in | input | 4 | Channel levels from the PWM generator |
| pwm_out | output | 4 | Channel levels to the pins |
| rst_counter | output | 1 | Synchronous reset strobe for the PWM counter |
| rst_reload | output | 1 | Synchronous reset strobe for the auto-reload register |
| rst_duty | output | 1 | Synchronous reset strobe for the duty-cycle registers |
| rst_mode | output | 1 | Synchronous reset strobe for the mode bits |
| irq | output | 1 | Break interrupt request, one-cycle pulse |

## Verification
The flag and `irq` are due three edges after the pin falls, or one edge after a clearing write. The output mux, the reset strobes and `bus_rdata` settle within the same cycle as the state they depend on. The bench drives its inputs just after a rising edge and samples one time unit later, so each check sees the state that follows a known number of edges. Break checks sample after the second edge to confirm the flag is still clear, then after the third edge to confirm it has set. The irq pulse is checked in its cycle and again in the cycle after it.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

    localparam int NCH         = 4;
    localparam int SYNC_STAGES = 2;
    localparam int DW          = 8;

    localparam int ARM_BIT  = 0;
    localparam int FLAG_BIT = 1;
    localparam int LVL_LSB  = 2;

    typedef struct packed {
        logic [NCH-1:0] lvl;
        logic           flag;
        logic           arm;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int PAD_W  = DW - CTRL_W;

    typedef struct packed {
        logic counter;
        logic reload;
        logic duty;
        logic mode;
    } tmr_rst_t;

    function automatic logic [DW-1:0] pack_rd(input ctrl_t c);
        return {{PAD_W{1'b0}}, c};
    endfunction

    function automatic tmr_rst_t fan_rst(input logic hold);
        tmr_rst_t r;
        r.counter = hold;
        r.reload  = hold;
        r.duty    = hold;
        r.mode    = hold;
        return r;
    endfunction

endpackage

// File: rtl/pbc_sync.sv
module pbc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= {STAGES{RST_VAL}};
        else     sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/pbc_latch.sv
module pbc_latch
    import pbc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          brk_seen,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output ctrl_t         ctrl,
    output logic          irq
);
    ctrl_t ctrl_q, ctrl_d;
    logic  irq_d;
    logic  clr_req;
    logic  set_req;

    assign clr_req = wr && !wdata[FLAG_BIT];
    assign set_req = ctrl_q.arm && brk_seen;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr) begin
            ctrl_d.arm = wdata[ARM_BIT];
            ctrl_d.lvl = wdata[LVL_LSB +: NCH];
        end
        if (clr_req)      ctrl_d.flag = 1'b0;
        else if (set_req) ctrl_d.flag = 1'b1;
        irq_d = ctrl_d.flag && !ctrl_q.flag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            irq    <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            irq    <= irq_d;
        end
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/pbc_outmux.sv
module pbc_outmux #(
    parameter int N = 4
) (
    input  logic         force_en,
    input  logic [N-1:0] safe_lvl,
    input  logic [N-1:0] live,
    output logic [N-1:0] outp
);
    for (genvar i = 0; i < N; i++) begin : g_ch
        assign outp[i] = force_en ? safe_lvl[i] : live[i];
    end
endmodule

// File: rtl/pwm_brk_ctrl.sv
module pwm_brk_ctrl
    import pbc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          brk_pin_n,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [NCH-1:0] pwm_in,
    output logic [NCH-1:0] pwm_out,
    output logic          rst_counter,
    output logic          rst_reload,
    output logic          rst_duty,
    output logic          rst_mode,
    output logic          irq
);
    logic     pin_sync_n;
    ctrl_t    ctrl;
    tmr_rst_t trst;

    pbc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (brk_pin_n),
        .q   (pin_sync_n)
    );

    pbc_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .brk_seen (!pin_sync_n),
        .wr       (bus_wr),
        .wdata    (bus_wdata),
        .ctrl     (ctrl),
        .irq      (irq)
    );

    pbc_outmux #(.N(NCH)) u_mux (
        .force_en (ctrl.flag),
        .safe_lvl (ctrl.lvl),
        .live     (pwm_in),
        .outp     (pwm_out)
    );

    assign trst        = fan_rst(ctrl.flag);
    assign rst_counter = trst.counter;
    assign rst_reload  = trst.reload;
    assign rst_duty    = trst.duty;
    assign rst_mode    = trst.mode;
    assign bus_rdata   = pack_rd(ctrl);
endmodule

// File: rtl/pbc_chk.sv
module pbc_chk
    import pbc_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           bus_wr,
    input logic [DW-1:0]  bus_wdata,
    input logic [DW-1:0]  bus_rdata,
    input logic [NCH-1:0] pwm_in,
    input logic [NCH-1:0] pwm_out,
    input logic           rst_counter,
    input logic           rst_reload,
    input logic           rst_duty,
    input logic           rst_mode,
    input logic           irq
);
    logic flag, arm;
    assign flag = bus_rdata[FLAG_BIT];
    assign arm  = bus_rdata[ARM_BIT];

    AST_NO_SET_DISARMED: assert property (@(posedge clk) disable iff (rst)
        (!$past(arm) && !$past(flag) && !$past(rst)) |-> !flag); // R2

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ($past(flag) && !$past(rst) && !$past(bus_wr && !bus_wdata[FLAG_BIT])) |-> flag); // R3

    AST_OUT_FORCED: assert property (@(posedge clk) disable iff (rst)
        flag |-> (pwm_out == bus_rdata[LVL_LSB +: NCH])); // R4

    AST_OUT_PASS: assert property (@(posedge clk) disable iff (rst)
        !flag |-> (pwm_out == pwm_in)); // R5

    AST_TMR_RESETS: assert property (@(posedge clk) disable iff (rst)
        ({rst_counter, rst_reload, rst_duty, rst_mode} == {4{flag}})); // R6

    AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag && !$past(flag))); // R7

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R7

    AST_RD_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DW-1:CTRL_W] == '0); // R9
endmodule

bind pwm_brk_ctrl pbc_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pwm_in      (pwm_in),
    .pwm_out     (pwm_out),
    .rst_counter (rst_counter),
    .rst_reload  (rst_reload),
    .rst_duty    (rst_duty),
    .rst_mode    (rst_mode),
    .irq         (irq)
);

// File: tb/pwm_brk_ctrl_bench.sv
`timescale 1ns/1ps
module pwm_brk_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       brk_pin_n = 1'b1;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] pwm_in = '0;
    logic [3:0] pwm_out;
    logic       rst_counter, rst_reload, rst_duty, rst_mode, irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    pwm_brk_ctrl u_pwm_brk_ctrl (
        .clk(clk), .rst(rst), .brk_pin_n(brk_pin_n),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_in(pwm_in), .pwm_out(pwm_out),
        .rst_counter(rst_counter), .rst_reload(rst_reload),
        .rst_duty(rst_duty), .rst_mode(rst_mode), .irq(irq)
    );

    // {safe levels, pwm_in}
    localparam logic [7:0] VEC [8] = '{
        8'h0F, 8'hF0, 8'hA5, 8'h5A, 8'h3C, 8'hC3, 8'h81, 8'h7E
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] d);
        bus_wr = 1'b1; bus_wdata = d;
        step(1);
        bus_wr = 1'b0;
    endtask

    function automatic logic [7:0] strobes();
        return {4'h0, rst_counter, rst_reload, rst_duty, rst_mode};
    endfunction

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R1 reset state
        chk("R1 rdata", bus_rdata, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 strobes", strobes(), 8'h00);
        pwm_in = 4'h9; #1;
        chk("R1 passthrough", {4'b0, pwm_out}, 8'h09);

        // R5 / R9 table walk with flag clear
        foreach (VEC[i]) begin
            wr({2'b00, VEC[i][7:4], 2'b01});
            pwm_in = VEC[i][3:0]; #1;
            chk("R9 stored", bus_rdata, {2'b00, VEC[i][7:4], 2'b01});
            chk("R5 passthrough", {4'b0, pwm_out}, {4'b0, VEC[i][3:0]});
        end

        // R2 armed break timing
        wr(8'b0001_0101);            // lvl=4'b0101, arm=1
        pwm_in = 4'hA;
        brk_pin_n = 1'b0;
        step(2);
        chk("R2 not yet", {7'b0, bus_rdata[1]}, 8'h00);
        step(1);
        chk("R2 flag set", {7'b0, bus_rdata[1]}, 8'h01);
        chk("R7 irq pulse", {7'b0, irq}, 8'h01);
        chk("R4 forced", {4'b0, pwm_out}, 8'h05);
        chk("R6 strobes", strobes(), 8'h0F);
        step(1);
        chk("R7 irq single", {7'b0, irq}, 8'h00);

        // R4 table walk with flag set (bit1=1 keeps it)
        foreach (VEC[i]) begin
            wr({2'b00, VEC[i][7:4], 2'b11});
            pwm_in = VEC[i][3:0]; #1;
            chk("R4 forced", {4'b0, pwm_out}, {4'b0, VEC[i][7:4]});
        end

        // R8 clear while pin low and armed
        wr(8'b0000_0001);
        chk("R8 cleared", {7'b0, bus_rdata[1]}, 8'h00);
        chk("R8 no irq", {7'b0, irq}, 8'h00);
        step(1);
        chk("R8 reset", {7'b0, bus_rdata[1]}, 8'h01);
        chk("R8 irq again", {7'b0, irq}, 8'h01);

        // R3 persistence: pin high, disarm with bit1=1
        brk_pin_n = 1'b1;
        step(4);
        chk("R3 pin high", {7'b0, bus_rdata[1]}, 8'h01);
        wr(8'b0000_0010);
        step(2);
        chk("R3 disarmed", bus_rdata, 8'h02);
        chk("R6 strobes held", strobes(), 8'h0F);
        wr(8'b0000_0000);
        chk("R3 clear", bus_rdata, 8'h00);
        chk("R6 strobes low", strobes(), 8'h00);

        // R2 disarmed: pin low has no effect; R9 software cannot set flag
        brk_pin_n = 1'b0;
        step(5);
        chk("R2 disarmed", bus_rdata, 8'h00);
        brk_pin_n = 1'b1;
        step(3);
        wr(8'hFE);
        chk("R9 no sw set", bus_rdata, 8'h3C);
        chk("R5 after sw write", {4'b0, pwm_out}, {4'b0, pwm_in});

        // R1 reset clears a set flag
        wr(8'h01);
        brk_pin_n = 1'b0;
        step(3);
        chk("R2 set again", {7'b0, bus_rdata[1]}, 8'h01);
        rst = 1'b1;
        step(1);
        rst = 1'b0;
        brk_pin_n = 1'b1;
        chk("R1 after reset", bus_rdata, 8'h00);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule